// File: doc/BRIEF.md
# EDO DRAM Device Emulator

This block is a synthesizable, scaled-down stand-in for a 16-bit-wide extended-data-out DRAM. A memory controller under verification drives it through the usual active-low strobes: a row strobe, two column strobes (one per byte lane), a write enable, an output enable and a 9-bit multiplexed address bus. The block captures the row and column halves of the address on strobe edges and keeps the data in an internal array whose size is set by parameters. It performs reads and writes on either or both byte lanes. Read data stays on the bus after a column strobe rises, as extended-data-out parts do.

Every strobe is sampled on the system clock, and an edge is the change between two consecutive samples. Analog access time is modelled as a count of clock edges. A column strobe that is already low when the row strobe falls starts a refresh-only cycle. During that cycle an internal row counter takes the place of the address, and the data bus stays undriven. A one-cycle error pulse flags a row-active period or a precharge period that is shorter than its configured minimum.

Top module: `edo_dram_model`

## Requirements
- R1: On the clock edge where `ras_n` is first sampled low, the row is captured from `addr[ROW_AW-1:0]` (default 3 bits). Higher address bits are ignored.
- R2: On the edge where the first of `lcas_n`/`ucas_n` is sampled low, the column is captured from `addr[COL_AW-1:0]`. A write updates only the lanes whose column strobe is low at commit: lane 0 is `dq[7:0]` with `lcas_n`, lane 1 is `dq[15:8]` with `ucas_n`.
- R3: `dq_oe[0]` depends only on `lcas_n` and `dq_oe[1]` only on `ucas_n`. A lane drives only while `ras_n` is low, `oe_n` is low and `we_n` is high. It is first driven after the ACC_CYC-th edge (default 2) following the column capture edge.
- R4: Read data and its lane enables stay valid after the column strobes rise. They are released on the edge that samples the next column-strobe fall, a `ras_n` high, an `oe_n` high or a `we_n` low.
- R5: A write commits on the edge where the later of column-strobe fall and `we_n` fall is seen. It stores `dq_in` as sampled on that edge, and later changes of `dq_in` have no effect.
- R6: Within one `ras_n`-low period, reads and writes to different columns of the open row may be interleaved in any order.
- R7: If a column strobe was low on the previous edge when `ras_n` falls, the cycle is refresh-only. The address is ignored, nothing is written even with `we_n` low, and `dq_oe` stays 0.
- R8: `rfsh_row` (9 bits, 0 after reset) increments by one on the edge where a refresh-only cycle ends with `ras_n` high, and wraps from 511 to 0.
- R9: `proto_err` pulses for one cycle when `ras_n` rises after fewer than RAS_MIN (default 4) low samples.
- R10: `proto_err` pulses for one cycle when `ras_n` falls after fewer than RP_MIN (default 3) high samples.
- R11: While reset is applied and after it is released, `dq_oe`, `dq_out`, `proto_err` and `rfsh_row` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the controller |
| dq_out | output | 16 | Read data, valid on lanes with `dq_oe` set |
| dq_oe | output | 2 | Per-lane drive enable, bit 1 is the upper lane |
| rfsh_row | output | 9 | Row counter used for refresh-only cycles |
| proto_err | output | 1 | One-cycle pulse on a strobe-timing violation |

## Verification
The stored row, the stored column and the lane-select state are only visible at the ports through the data a later read returns. An error in any of them therefore shows up on the first read of an affected location, ACC_CYC edges after that read's column strobe falls. A wrong refresh flag shows on `dq_oe` or in memory contents within the same cycle. A drift in the refresh counter shows on `rfsh_row` one edge after the refresh cycle closes. A wrong timing counter produces a false or missing `proto_err` pulse on the very next `ras_n` transition.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DQ_W   = LANES * LANE_W;

  typedef logic [LANES-1:0] lane_t;
  typedef logic [DQ_W-1:0]  word_t;
endpackage

// File: rtl/edo_rst_sync.sv
module edo_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/edo_strobe_ctrl.sv
// Samples the strobes, tracks the open row and column cycle, and produces
// the write strobe and the read-ready / lane-select state.
module edo_strobe_ctrl #(
  parameter int ADDR_W  = 9,
  parameter int ROW_AW  = 3,
  parameter int COL_AW  = 3,
  parameter int ACC_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic                 lcas_n,
  input  logic                 ucas_n,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    addr,
  output logic [ROW_AW-1:0]    row_q,
  output logic [COL_AW-1:0]    col_q,
  output logic [COL_AW-1:0]    wr_col,
  output logic                 wr_stb,
  output edo_pkg::lane_t       wr_lanes,
  output edo_pkg::lane_t       lane_rd,
  output logic                 rd_rdy,
  output logic                 ras_fall_ev,
  output logic                 ras_rise_ev,
  output logic                 cbr_done
);
  import edo_pkg::*;

  localparam int WCW = $clog2(ACC_CYC + 1);
  localparam logic [WCW-1:0] ACC_LOAD = WCW'(ACC_CYC);
  localparam logic [WCW-1:0] ONE_C    = WCW'(1);

  // previous samples
  logic ras_d_q, cas_lo_d_q, we_d_q;
  // cycle state
  logic act_q, act_nx;
  logic cbr_q, cbr_nx;
  logic [ROW_AW-1:0] row_nx;
  logic [COL_AW-1:0] col_nx;
  lane_t sel_q, sel_nx;
  logic [WCW-1:0] wcnt_q, wcnt_nx;

  logic  cas_lo, cas_fall_ev, we_fall_ev, open_pg, col_stb;
  lane_t lane_low;
  logic  addr_unused;

  assign addr_unused = ^addr;
  assign lane_low    = ~{ucas_n, lcas_n};
  assign cas_lo      = |lane_low;
  assign ras_fall_ev = ras_d_q & ~ras_n;
  assign ras_rise_ev = ~ras_d_q & ras_n;
  assign cas_fall_ev = ~cas_lo_d_q & cas_lo;
  assign we_fall_ev  = we_d_q & ~we_n;
  assign open_pg     = act_q & ~cbr_q & ~ras_n;
  assign col_stb     = open_pg & cas_fall_ev;

  assign wr_stb   = open_pg & cas_lo & ~we_n & (cas_fall_ev | we_fall_ev);
  assign wr_col   = cas_fall_ev ? addr[COL_AW-1:0] : col_q;
  assign wr_lanes = lane_low;
  assign cbr_done = ras_rise_ev & cbr_q;
  assign rd_rdy   = open_pg & ~cas_fall_ev & (wcnt_q <= ONE_C);
  assign lane_rd  = sel_q | (we_n ? lane_low : '0);

  always_comb begin
    act_nx  = act_q;
    cbr_nx  = cbr_q;
    row_nx  = row_q;
    col_nx  = col_q;
    sel_nx  = sel_q;
    wcnt_nx = wcnt_q;

    if (ras_fall_ev) begin
      act_nx = 1'b1;
      cbr_nx = cas_lo_d_q & cas_lo;
      if (!(cas_lo_d_q & cas_lo)) row_nx = addr[ROW_AW-1:0];
    end else if (ras_rise_ev) begin
      act_nx = 1'b0;
      cbr_nx = 1'b0;
    end

    if (col_stb) col_nx = addr[COL_AW-1:0];

    if (ras_n)        sel_nx = '0;
    else if (col_stb) sel_nx = we_n ? lane_low : '0;
    else if (wr_stb)  sel_nx = '0;
    else if (open_pg && we_n) sel_nx = sel_q | lane_low;

    if (col_stb)                wcnt_nx = ACC_LOAD;
    else if (wcnt_q != '0)      wcnt_nx = wcnt_q - ONE_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_d_q    <= 1'b1;
      cas_lo_d_q <= 1'b0;
      we_d_q     <= 1'b1;
      act_q      <= 1'b0;
      cbr_q      <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      sel_q      <= '0;
      wcnt_q     <= '0;
    end else begin
      ras_d_q    <= ras_n;
      cas_lo_d_q <= cas_lo;
      we_d_q     <= we_n;
      act_q      <= act_nx;
      cbr_q      <= cbr_nx;
      row_q      <= row_nx;
      col_q      <= col_nx;
      sel_q      <= sel_nx;
      wcnt_q     <= wcnt_nx;
    end
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int ROW_AW = 3,
  parameter int COL_AW = 3
) (
  input  logic                 clk,
  input  logic                 wr_stb,
  input  logic [ROW_AW-1:0]    wr_row,
  input  logic [COL_AW-1:0]    wr_col,
  input  edo_pkg::lane_t       wr_lanes,
  input  edo_pkg::word_t       wr_data,
  input  logic [ROW_AW-1:0]    rd_row,
  input  logic [COL_AW-1:0]    rd_col,
  output edo_pkg::word_t       rd_data
);
  import edo_pkg::*;

  localparam int AW    = ROW_AW + COL_AW;
  localparam int DEPTH = 1 << AW;

  word_t cells [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;

  assign wr_idx  = {wr_row, wr_col};
  assign rd_idx  = {rd_row, rd_col};
  assign rd_data = cells[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_stb) begin
      for (int ln = 0; ln < LANES; ln++) begin
        if (wr_lanes[ln]) cells[wr_idx][ln*LANE_W +: LANE_W] <= wr_data[ln*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/edo_timing_guard.sv
module edo_timing_guard #(
  parameter int RAS_MIN = 4,
  parameter int RP_MIN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic ras_fall_ev,
  input  logic ras_rise_ev,
  output logic viol_q
);
  localparam int MAXV = (RAS_MIN > RP_MIN) ? RAS_MIN : RP_MIN;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] MAX_C  = CW'(MAXV);
  localparam logic [CW-1:0] RAS_C  = CW'(RAS_MIN);
  localparam logic [CW-1:0] RP_C   = CW'(RP_MIN);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [CW-1:0] lo_q, lo_nx, hi_q, hi_nx;
  logic viol_nx;

  always_comb begin
    lo_nx = lo_q;
    hi_nx = hi_q;
    if (ras_fall_ev)                 lo_nx = ONE_C;
    else if (!ras_n && lo_q != MAX_C) lo_nx = lo_q + ONE_C;
    if (ras_rise_ev)                 hi_nx = ONE_C;
    else if (ras_n && hi_q != MAX_C)  hi_nx = hi_q + ONE_C;
    viol_nx = (ras_rise_ev && lo_q < RAS_C) || (ras_fall_ev && hi_q < RP_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= MAX_C;
      viol_q <= 1'b0;
    end else begin
      lo_q   <= lo_nx;
      hi_q   <= hi_nx;
      viol_q <= viol_nx;
    end
  end
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = step ? cnt_q + CW'(1) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
  parameter int ADDR_W  = 9,
  parameter int ROW_AW  = 3,
  parameter int COL_AW  = 3,
  parameter int ACC_CYC = 2,
  parameter int RAS_MIN = 4,
  parameter int RP_MIN  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ras_n,
  input  logic                      lcas_n,
  input  logic                      ucas_n,
  input  logic                      we_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [edo_pkg::DQ_W-1:0]  dq_in,
  output logic [edo_pkg::DQ_W-1:0]  dq_out,
  output logic [edo_pkg::LANES-1:0] dq_oe,
  output logic [ADDR_W-1:0]         rfsh_row,
  output logic                      proto_err
);
  import edo_pkg::*;

  logic rst_i;
  logic [ROW_AW-1:0] row_q;
  logic [COL_AW-1:0] col_q, wr_col;
  logic  wr_stb, rd_rdy, ras_fall_ev, ras_rise_ev, cbr_done;
  lane_t wr_lanes, lane_rd;
  word_t rd_word;

  edo_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_i)
  );

  edo_strobe_ctrl #(
    .ADDR_W (ADDR_W), .ROW_AW (ROW_AW), .COL_AW (COL_AW), .ACC_CYC (ACC_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_i),
    .ras_n       (ras_n),
    .lcas_n      (lcas_n),
    .ucas_n      (ucas_n),
    .we_n        (we_n),
    .addr        (addr),
    .row_q       (row_q),
    .col_q       (col_q),
    .wr_col      (wr_col),
    .wr_stb      (wr_stb),
    .wr_lanes    (wr_lanes),
    .lane_rd     (lane_rd),
    .rd_rdy      (rd_rdy),
    .ras_fall_ev (ras_fall_ev),
    .ras_rise_ev (ras_rise_ev),
    .cbr_done    (cbr_done)
  );

  edo_cell_array #(.ROW_AW (ROW_AW), .COL_AW (COL_AW)) u_cells (
    .clk      (clk),
    .wr_stb   (wr_stb),
    .wr_row   (row_q),
    .wr_col   (wr_col),
    .wr_lanes (wr_lanes),
    .wr_data  (dq_in),
    .rd_row   (row_q),
    .rd_col   (col_q),
    .rd_data  (rd_word)
  );

  edo_timing_guard #(.RAS_MIN (RAS_MIN), .RP_MIN (RP_MIN)) u_guard (
    .clk         (clk),
    .rst_n       (rst_i),
    .ras_n       (ras_n),
    .ras_fall_ev (ras_fall_ev),
    .ras_rise_ev (ras_rise_ev),
    .viol_q      (proto_err)
  );

  edo_refresh_ctr #(.CW (ADDR_W)) u_rfsh (
    .clk   (clk),
    .rst_n (rst_i),
    .step  (cbr_done),
    .cnt_q (rfsh_row)
  );

  // per-lane registered drivers
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              drv_nx, drv_q;
    logic [LANE_W-1:0] byte_nx, byte_q;

    assign drv_nx  = rd_rdy & ~oe_n & we_n & lane_rd[g];
    assign byte_nx = drv_nx ? rd_word[g*LANE_W +: LANE_W] : '0;

    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) begin
        drv_q  <= 1'b0;
        byte_q <= '0;
      end else begin
        drv_q  <= drv_nx;
        byte_q <= byte_nx;
      end
    end

    assign dq_oe[g]                    = drv_q;
    assign dq_out[g*LANE_W +: LANE_W]  = byte_q;
  end
endmodule

// File: rtl/edo_dram_model_chk.sv
module edo_dram_model_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              lcas_n,
  input logic              ucas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [1:0]        dq_oe,
  input logic [ADDR_W-1:0] rfsh_row,
  input logic              proto_err
);
  logic ras_d_q, cas_d_q, cbr_q;
  logic cas_lo;

  assign cas_lo = ~(lcas_n & ucas_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_d_q <= 1'b1;
      cas_d_q <= 1'b0;
      cbr_q   <= 1'b0;
    end else begin
      ras_d_q <= ras_n;
      cas_d_q <= cas_lo;
      if (ras_n)                                   cbr_q <= 1'b0;
      else if (ras_d_q && cas_d_q && cas_lo)       cbr_q <= 1'b1;
    end
  end

  a_r3_ras_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n) |-> dq_oe == 2'b00);

  a_r3_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n) |-> dq_oe == 2'b00);

  a_r3_we_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_n) |-> dq_oe == 2'b00);

  a_r7_cbr_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_q |-> dq_oe == 2'b00);

  a_r8_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_row != $past(rfsh_row)) |->
      (rfsh_row == $past(rfsh_row) + 9'd1) && $past(ras_n) && !$past(ras_n, 2));

  a_r9_err_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(ras_n) != $past(ras_n, 2));
endmodule

bind edo_dram_model edo_dram_model_chk #(.ADDR_W (ADDR_W)) u_chk (.*);

// File: tb/edo_dram_model_test.sv
module edo_dram_model_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [8:0]  rfsh_row;
  logic        proto_err;

  int n_tests = 0, n_fail = 0, perr_seen = 0;
  logic [15:0] shadow [64];

  always #2.5 clk = ~clk;

  edo_dram_model uut (
    .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .lcas_n (lcas_n), .ucas_n (ucas_n),
    .we_n (we_n), .oe_n (oe_n), .addr (addr), .dq_in (dq_in), .dq_out (dq_out),
    .dq_oe (dq_oe), .rfsh_row (rfsh_row), .proto_err (proto_err)
  );

  always @(negedge clk) if (proto_err === 1'b1) perr_seen++;

  // op(1=write) | row | col | lanes | data
  localparam logic [24:0] VEC [12] = '{
    {1'b1, 3'd1, 3'd2, 2'b11, 16'hA5C3},
    {1'b1, 3'd3, 3'd7, 2'b11, 16'h1E2F},
    {1'b1, 3'd7, 3'd0, 2'b11, 16'h8421},
    {1'b0, 3'd1, 3'd2, 2'b11, 16'h0000},
    {1'b1, 3'd1, 3'd2, 2'b01, 16'h00FF},
    {1'b0, 3'd1, 3'd2, 2'b11, 16'h0000},
    {1'b1, 3'd3, 3'd7, 2'b10, 16'hBE00},
    {1'b0, 3'd3, 3'd7, 2'b10, 16'h0000},
    {1'b0, 3'd3, 3'd7, 2'b01, 16'h0000},
    {1'b0, 3'd7, 3'd0, 2'b11, 16'h0000},
    {1'b1, 3'd0, 3'd5, 2'b11, 16'h7777},
    {1'b0, 3'd0, 3'd5, 2'b01, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] lmask(input logic [1:0] ln);
    return {{8{ln[1]}}, {8{ln[0]}}};
  endfunction

  task automatic wr(input logic [2:0] row, input logic [2:0] col, input logic [1:0] ln,
                    input logic [15:0] d);
    @(negedge clk); ras_n = 1'b0; addr = {6'b101101, row}; oe_n = 1'b1;
    @(negedge clk); addr = {6'b110010, col}; we_n = 1'b0; dq_in = d;
    @(negedge clk); lcas_n = ~ln[0]; ucas_n = ~ln[1];
    @(negedge clk); lcas_n = 1'b1; ucas_n = 1'b1; dq_in = ~d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ras_n = 1'b1;
    tick(4);
    shadow[{row, col}] = (shadow[{row, col}] & ~lmask(ln)) | (d & lmask(ln));
  endtask

  task automatic rd(input logic [2:0] row, input logic [2:0] col, input logic [1:0] ln);
    @(negedge clk); ras_n = 1'b0; addr = {6'b011011, row}; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); addr = {6'b100111, col};
    @(negedge clk); lcas_n = ~ln[0]; ucas_n = ~ln[1];
    tick(2);
    check("R3 not driven before access count", {30'd0, dq_oe}, 32'd0);
    tick(1);
    check("R3 lane enables", {30'd0, dq_oe}, {30'd0, ln});
    check("R1 R2 read data", {16'd0, dq_out & lmask(ln)}, {16'd0, shadow[{row, col}] & lmask(ln)});
    lcas_n = 1'b1; ucas_n = 1'b1;
    tick(2);
    check("R4 held after CAS rise", {14'd0, dq_oe, dq_out & lmask(ln)},
          {14'd0, ln, shadow[{row, col}] & lmask(ln)});
    ras_n = 1'b1; oe_n = 1'b1;
    tick(1);
    check("R4 released on RAS rise", {30'd0, dq_oe}, 32'd0);
    tick(4);
  endtask

  task automatic cbr(input logic we, input logic [8:0] a, input logic chk_en);
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0; oe_n = 1'b0; we_n = we; dq_in = 16'hFFFF;
    @(negedge clk); ras_n = 1'b0; addr = a;
    tick(4);
    if (chk_en) check("R7 bus undriven in refresh", {30'd0, dq_oe}, 32'd0);
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    tick(3);
    check("R11 reset outputs", {dq_oe, proto_err, rfsh_row, dq_out}, 28'd0);
    rst_n = 1'b1;
    tick(4);
    check("R11 after release", {dq_oe, proto_err, rfsh_row, dq_out}, 28'd0);

    // table walk
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][24]) wr(VEC[i][23:21], VEC[i][20:18], VEC[i][17:16], VEC[i][15:0]);
      else            rd(VEC[i][23:21], VEC[i][20:18], VEC[i][17:16]);
    end
    check("R9 R10 no error on legal cycles", perr_seen, 0);

    // page mode: EDO hold, release on next CAS fall, mixed read/write
    wr(3'd2, 3'd3, 2'b11, 16'h1234);
    wr(3'd2, 3'd4, 2'b11, 16'h5678);
    @(negedge clk); ras_n = 1'b0; addr = 9'd2; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); addr = 9'd3;
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0;
    tick(3);
    check("R3 page read col3", {16'd0, dq_out}, 32'h1234);
    lcas_n = 1'b1; ucas_n = 1'b1;
    tick(2);
    check("R4 EDO hold", {14'd0, dq_oe, dq_out}, {14'd0, 2'b11, 16'h1234});
    addr = 9'd4; lcas_n = 1'b0; ucas_n = 1'b0;
    tick(1);
    check("R4 release at next CAS fall", {30'd0, dq_oe}, 32'd0);
    tick(2);
    check("R6 page read col4", {14'd0, dq_oe, dq_out}, {14'd0, 2'b11, 16'h5678});
    lcas_n = 1'b1; ucas_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); addr = 9'd5; we_n = 1'b0; dq_in = 16'h9ABC;
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0;
    @(negedge clk); lcas_n = 1'b1; ucas_n = 1'b1; dq_in = 16'h0000;
    @(negedge clk); we_n = 1'b1; oe_n = 1'b0; addr = 9'd3;
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0;
    tick(3);
    check("R6 read after in-page write", {16'd0, dq_out}, 32'h1234);
    lcas_n = 1'b1; ucas_n = 1'b1; addr = 9'd5;
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0;
    tick(3);
    check("R6 in-page written word", {14'd0, dq_oe, dq_out}, {14'd0, 2'b11, 16'h9ABC});
    lcas_n = 1'b1; ucas_n = 1'b1;
    @(negedge clk); ras_n = 1'b1;
    tick(1);
    check("R4 released on RAS high", {30'd0, dq_oe}, 32'd0);
    tick(4);
    shadow[{3'd2, 3'd5}] = 16'h9ABC;

    // output enable high: nothing driven
    @(negedge clk); ras_n = 1'b0; addr = 9'd2; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk); addr = 9'd3;
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0;
    tick(3);
    check("R3 OE high keeps bus undriven", {30'd0, dq_oe}, 32'd0);
    oe_n = 1'b0;
    tick(1);
    check("R3 OE low drives held read", {14'd0, dq_oe, dq_out}, {14'd0, 2'b11, 16'h1234});
    lcas_n = 1'b1; ucas_n = 1'b1;
    @(negedge clk); oe_n = 1'b1;
    tick(1);
    check("R4 released on OE high", {30'd0, dq_oe}, 32'd0);
    ras_n = 1'b1;
    tick(4);

    // late WE: CAS first, WE later, data sampled at WE fall
    @(negedge clk); ras_n = 1'b0; addr = 9'd6; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); addr = 9'd1;
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0; dq_in = 16'h1111;
    @(negedge clk); dq_in = 16'hCAFE;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); dq_in = 16'h0000;
    @(negedge clk); lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1;
    @(negedge clk); ras_n = 1'b1;
    tick(4);
    shadow[{3'd6, 3'd1}] = 16'hCAFE;
    rd(3'd6, 3'd1, 2'b11);
    check("R5 late-WE write data", {16'd0, shadow[{3'd6, 3'd1}]}, 32'hCAFE);

    // refresh-only cycle with WE low must not write, bus undriven
    wr(3'd0, 3'd0, 2'b11, 16'h0F0F);
    cbr(1'b0, 9'd0, 1'b1);
    check("R8 counter after first refresh", {23'd0, rfsh_row}, 32'd1);
    rd(3'd0, 3'd0, 2'b11);
    check("R9 R10 no error through refresh", perr_seen, 0);

    // counter wrap
    for (int k = 0; k < 510; k++) cbr(1'b1, 9'h1FF, 1'b0);
    check("R8 counter at 511", {23'd0, rfsh_row}, 32'd511);
    cbr(1'b1, 9'h0AA, 1'b0);
    check("R8 counter wraps to 0", {23'd0, rfsh_row}, 32'd0);

    // short RAS active
    @(negedge clk); ras_n = 1'b0; addr = 9'd1;
    @(negedge clk);
    @(negedge clk); ras_n = 1'b1;
    tick(4);
    check("R9 short RAS flagged", perr_seen, 1);

    // short precharge
    @(negedge clk); ras_n = 1'b0;
    tick(5);
    ras_n = 1'b1;
    @(negedge clk); ras_n = 1'b0;
    tick(5);
    ras_n = 1'b1;
    tick(4);
    check("R10 short precharge flagged", perr_seen, 2);

    // reset in mid-run clears the counter
    cbr(1'b1, 9'd0, 1'b0);
    check("R8 counter before reset", {23'd0, rfsh_row}, 32'd1);
    rst_n = 1'b0;
    tick(2);
    check("R11 reset clears state", {dq_oe, proto_err, rfsh_row}, 12'd0);
    rst_n = 1'b1;
    tick(4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule